// File: doc/BRIEF.md
# Multi-Channel Power and Energy Accumulator

This block turns a stream of per-channel voltage samples into power and energy figures. On every sample period it walks through the channels enabled in a mask, lowest index first. For each one it asks for a conversion and waits until that channel's sample is presented. It multiplies the signed sense-voltage code by the upper bits of the unsigned bus-voltage code. It keeps that product as the channel's latest power value and adds it into a per-channel signed energy accumulator. A single shared counter records how many complete scans have been accumulated since the last clear.

The sample period comes from a divider on the system clock. A 2-bit rate field selects 8, 64, 256 or 1024 periods per second. The scan is run by a four-state machine. In IDLE it waits for a period tick and a non-empty mask, captures the mask and moves to PICK. PICK moves to WAIT when the current index is enabled, steps the index past a disabled channel, and moves to DONE once the index has passed the last channel. WAIT returns to PICK with the next index when the requested sample is accepted. DONE lasts one cycle, advances the scan count and returns to IDLE.

A refresh input clears the energy state. A sticky overflow flag and the scan-complete pulse can each be enabled onto a single alert line.

Top module: `pwr_energy_acc`

## Requirements
- R1: After a period tick with a non-zero `chan_mask`, `smp_req` requests each enabled channel in ascending index order on `req_chan` and skips disabled ones. The mask is captured when the scan starts.
- R2: A sample is accepted only in a cycle where `smp_req` is high, `smp_valid` is high and `smp_chan` equals `req_chan`. A sample presented on `smp_valid` in any other cycle changes no accumulator and no power value.
- R3: The power for an accepted sample is floor((signed `smp_sense`) × `smp_bus[15:2]` / 8), kept as a 28-bit signed value. It appears on `pwr_flat[ch*28 +: 28]` in the cycle after acceptance.
- R4: In the same cycle, the power, sign-extended to ACC_W bits (48 by default), is added to the channel's accumulator on `acc_flat[ch*ACC_W +: ACC_W]`. The sum wraps modulo 2^ACC_W.
- R5: `acc_count` (CNT_W bits, 24 by default) rises by one in the cycle after each completed scan and wraps from all ones to zero.
- R6: `scan_done` is high for exactly one cycle at the end of each scan, after the last enabled channel has been accepted.
- R7: Period ticks occur every CLK_HZ/rate clock cycles, where `rate_sel` 0, 1, 2, 3 select rate 8, 64, 256, 1024.
- R8: While `chan_mask` is zero, a tick starts no scan: there are no requests, no `scan_done` and no change to `acc_count`.
- R9: A signed overflow of any accumulator add, or a wrap of `acc_count`, sets an overflow flag. The flag stays set until a refresh. While `ovf_alert_en` is high, `alert` follows the flag.
- R10: While `done_alert_en` is high, `alert` is high in the `scan_done` cycle. While it is low, `scan_done` does not raise `alert`.
- R11: A `refresh` cycle zeroes all accumulators, `acc_count` and the overflow flag. A sample accepted in the same cycle is added to the cleared value.
- R12: After reset, the accumulators, power values and count are zero, and `smp_req`, `scan_done` and `alert` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_mask | input | NCH | Enabled channels, bit g for channel g |
| rate_sel | input | 2 | Sample-rate select (8/64/256/1024 per second) |
| refresh | input | 1 | Clear accumulators, count and overflow flag |
| ovf_alert_en | input | 1 | Route the overflow flag to `alert` |
| done_alert_en | input | 1 | Route the scan-complete pulse to `alert` |
| smp_req | output | 1 | Conversion request for `req_chan` |
| req_chan | output | CH_W | Channel being requested |
| smp_valid | input | 1 | Sample present on `smp_chan`, `smp_bus`, `smp_sense` |
| smp_chan | input | CH_W | Channel index of the presented sample |
| smp_bus | input | 16 | Unsigned bus-voltage code |
| smp_sense | input | 16 | Two's complement sense-voltage code |
| pwr_flat | output | NCH*28 | Latest power per channel |
| acc_flat | output | NCH*ACC_W | Energy accumulator per channel |
| acc_count | output | CNT_W | Completed scans since the last clear |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| alert | output | 1 | Combined enabled alert |

## Verification
The assertions rely on `refresh` not being driven during the `scan_done` cycle. They also rely on the sample source holding `chan_mask` steady while a scan is in progress, so that a scan's count step and its clear never collide. The stimulus keeps to this by changing the mask and rate and driving the standalone refresh only right after a scan has finished, while the block sits in IDLE. The refresh that tests a same-cycle sample is driven together with an accepted sample and never at scan end. Samples are returned only while a request is open, apart from deliberate stray and wrong-channel presentations.

// File: rtl/pea_pkg.sv
package pea_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_PICK,
        SCAN_WAIT,
        SCAN_DONE
    } scan_state_e;

    // Clock cycles per sample period for a given rate selection.
    function automatic int unsigned rate_div(input int unsigned clk_hz, input logic [1:0] sel);
        int unsigned rate;
        unique case (sel)
            2'd0:    rate = 8;
            2'd1:    rate = 64;
            2'd2:    rate = 256;
            default: rate = 1024;
        endcase
        return (clk_hz / rate > 0) ? clk_hz / rate : 1;
    endfunction

endpackage

// File: rtl/pea_tick_gen.sv
module pea_tick_gen #(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int unsigned DIV_MAX = CLK_HZ / 8 + 1;
    localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(pea_pkg::rate_div(CLK_HZ, rate_sel) - 1);
        tick  = (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/pea_power_calc.sv
module pea_power_calc #(
    parameter int SNS_W    = 16,
    parameter int BUS_W    = 16,
    parameter int BUS_KEEP = 14,
    parameter int PWR_W    = 28
) (
    input  logic [BUS_W-1:0]        bus,
    input  logic [SNS_W-1:0]        sense,
    output logic signed [PWR_W-1:0] power
);
    localparam int PROD_W = SNS_W + BUS_KEEP + 1;

    logic signed [BUS_KEEP:0]     bus_s;
    logic signed [PROD_W-1:0]     prod;
    logic [BUS_W-BUS_KEEP-1:0]    bus_frac_unused;

    assign bus_frac_unused = bus[BUS_W-BUS_KEEP-1:0];
    assign bus_s = {1'b0, bus[BUS_W-1 -: BUS_KEEP]};
    assign prod  = PROD_W'($signed(sense)) * PROD_W'(bus_s);
    // Dropping low bits of a two's complement product rounds toward minus infinity.
    assign power = prod[PROD_W-1 -: PWR_W];
endmodule

// File: rtl/pea_acc_bank.sv
module pea_acc_bank #(
    parameter int NCH   = 4,
    parameter int PWR_W = 28,
    parameter int ACC_W = 48,
    parameter int CNT_W = 24,
    parameter int CH_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic signed [PWR_W-1:0] wr_pwr,
    input  logic                    cnt_inc,
    output logic [NCH*ACC_W-1:0]    acc_flat,
    output logic [NCH*PWR_W-1:0]    pwr_flat,
    output logic [CNT_W-1:0]        count,
    output logic                    ovf_flag
);
    logic [NCH-1:0]   ovf_hit;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_base;
    logic             cnt_wrap;
    logic             ovf_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] base;
        logic signed [ACC_W-1:0] addend;
        logic signed [ACC_W-1:0] sum;
        logic signed [PWR_W-1:0] pwr_q;
        logic                    hit;

        assign hit        = wr_en && (wr_ch == CH_W'(g));
        assign base       = clear ? '0 : acc_q;
        assign addend     = ACC_W'(wr_pwr);
        assign sum        = base + addend;
        assign ovf_hit[g] = hit && (base[ACC_W-1] == addend[ACC_W-1])
                                && (sum[ACC_W-1] != base[ACC_W-1]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
                pwr_q <= '0;
            end else if (hit) begin
                acc_q <= sum;
                pwr_q <= wr_pwr;
            end else if (clear) begin
                acc_q <= '0;
            end
        end

        assign acc_flat[g*ACC_W +: ACC_W] = acc_q;
        assign pwr_flat[g*PWR_W +: PWR_W] = pwr_q;
    end

    assign cnt_base = clear ? '0 : cnt_q;
    assign cnt_wrap = cnt_inc && (&cnt_base);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_inc ? cnt_base + CNT_W'(1) : cnt_base;
            ovf_q <= (clear ? 1'b0 : ovf_q) | (|ovf_hit) | cnt_wrap;
        end
    end

    assign count    = cnt_q;
    assign ovf_flag = ovf_q;
endmodule

// File: rtl/pwr_energy_acc.sv
module pwr_energy_acc #(
    parameter int unsigned CLK_HZ = 1_000_000,
    parameter int          NCH    = 4,
    parameter int          ACC_W  = 48,
    parameter int          CNT_W  = 24,
    localparam int         CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int         PWR_W  = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       chan_mask,
    input  logic [1:0]           rate_sel,
    input  logic                 refresh,
    input  logic                 ovf_alert_en,
    input  logic                 done_alert_en,
    output logic                 smp_req,
    output logic [CH_W-1:0]      req_chan,
    input  logic                 smp_valid,
    input  logic [CH_W-1:0]      smp_chan,
    input  logic [15:0]          smp_bus,
    input  logic [15:0]          smp_sense,
    output logic [NCH*PWR_W-1:0] pwr_flat,
    output logic [NCH*ACC_W-1:0] acc_flat,
    output logic [CNT_W-1:0]     acc_count,
    output logic                 scan_done,
    output logic                 alert
);
    import pea_pkg::*;

    localparam int IDX_W = $clog2(NCH + 1);

    scan_state_e             state_q, state_d;
    logic [IDX_W-1:0]        ch_idx_q, ch_idx_d;
    logic [NCH-1:0]          mask_q, mask_d;
    logic [CH_W-1:0]         ch_sel;
    logic                    tick;
    logic                    accept;
    logic                    ovf_flag;
    logic signed [PWR_W-1:0] power;

    pea_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    pea_power_calc #(.SNS_W(16), .BUS_W(16), .BUS_KEEP(14), .PWR_W(PWR_W)) u_pwr (
        .bus   (smp_bus),
        .sense (smp_sense),
        .power (power)
    );

    assign ch_sel = ch_idx_q[CH_W-1:0];
    assign accept = (state_q == SCAN_WAIT) && smp_valid && (smp_chan == ch_sel);

    // Next-state logic for the scan sequencer.
    always_comb begin
        state_d  = state_q;
        ch_idx_d = ch_idx_q;
        mask_d   = mask_q;
        unique case (state_q)
            SCAN_IDLE: begin
                if (tick && (|chan_mask)) begin
                    mask_d   = chan_mask;
                    ch_idx_d = '0;
                    state_d  = SCAN_PICK;
                end
            end
            SCAN_PICK: begin
                if (ch_idx_q == IDX_W'(NCH))  state_d  = SCAN_DONE;
                else if (mask_q[ch_sel])      state_d  = SCAN_WAIT;
                else                          ch_idx_d = ch_idx_q + IDX_W'(1);
            end
            SCAN_WAIT: begin
                if (accept) begin
                    ch_idx_d = ch_idx_q + IDX_W'(1);
                    state_d  = SCAN_PICK;
                end
            end
            SCAN_DONE: state_d = SCAN_IDLE;
            default:   state_d = SCAN_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SCAN_IDLE;
            ch_idx_q <= '0;
            mask_q   <= '0;
        end else begin
            state_q  <= state_d;
            ch_idx_q <= ch_idx_d;
            mask_q   <= mask_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        smp_req   = (state_q == SCAN_WAIT);
        req_chan  = ch_sel;
        scan_done = (state_q == SCAN_DONE);
        alert     = (ovf_alert_en && ovf_flag) || (done_alert_en && scan_done);
    end

    pea_acc_bank #(
        .NCH   (NCH),
        .PWR_W (PWR_W),
        .ACC_W (ACC_W),
        .CNT_W (CNT_W),
        .CH_W  (CH_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (refresh),
        .wr_en    (accept),
        .wr_ch    (ch_sel),
        .wr_pwr   (power),
        .cnt_inc  (scan_done),
        .acc_flat (acc_flat),
        .pwr_flat (pwr_flat),
        .count    (acc_count),
        .ovf_flag (ovf_flag)
    );
endmodule

// File: rtl/pea_checker.sv
module pea_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             refresh,
    input logic             scan_done,
    input logic             alert,
    input logic             done_alert_en,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] acc_count
);
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> acc_count == $past(acc_count) + CNT_W'($past(scan_done)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !refresh |=> ovf_flag);

    a_r10_done_alert: assert property (@(posedge clk) disable iff (!rst_n)
        done_alert_en && scan_done |-> alert);

    a_r11_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        refresh && !scan_done |=> acc_count == '0);

    a_r11_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !ovf_flag);
endmodule

bind pwr_energy_acc pea_checker #(.CNT_W(CNT_W)) u_pea_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh       (refresh),
    .scan_done     (scan_done),
    .alert         (alert),
    .done_alert_en (done_alert_en),
    .ovf_flag      (ovf_flag),
    .acc_count     (acc_count)
);

// File: tb/test_pwr_energy_acc.sv
module test_pwr_energy_acc;
    localparam int NCH    = 4;
    localparam int ACC_W  = 32;
    localparam int CNT_W  = 6;
    localparam int PWR_W  = 28;
    localparam int CH_W   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NCH-1:0] chan_mask;
    logic [1:0]     rate_sel;
    logic           ovf_alert_en, done_alert_en;
    logic           m_refresh, r_refresh, refresh;
    logic           m_valid, r_valid;
    logic [CH_W-1:0] m_chan, r_chan;
    logic [15:0]    m_bus, r_bus, m_sense, r_sense;
    logic           smp_valid;
    logic [CH_W-1:0] smp_chan;
    logic [15:0]    smp_bus, smp_sense;
    logic           smp_req;
    logic [CH_W-1:0] req_chan;
    logic [NCH*PWR_W-1:0] pwr_flat;
    logic [NCH*ACC_W-1:0] acc_flat;
    logic [CNT_W-1:0] acc_count;
    logic           scan_done, alert;

    assign refresh   = m_refresh | r_refresh;
    assign smp_valid = r_valid | m_valid;
    assign smp_chan  = r_valid ? r_chan  : m_chan;
    assign smp_bus   = r_valid ? r_bus   : m_bus;
    assign smp_sense = r_valid ? r_sense : m_sense;

    pwr_energy_acc #(.CLK_HZ(65536), .NCH(NCH), .ACC_W(ACC_W), .CNT_W(CNT_W)) i_pwr_energy_acc (
        .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .rate_sel(rate_sel),
        .refresh(refresh), .ovf_alert_en(ovf_alert_en), .done_alert_en(done_alert_en),
        .smp_req(smp_req), .req_chan(req_chan), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_bus(smp_bus), .smp_sense(smp_sense), .pwr_flat(pwr_flat), .acc_flat(acc_flat),
        .acc_count(acc_count), .scan_done(scan_done), .alert(alert)
    );

    typedef struct {
        int                      ch;
        logic signed [PWR_W-1:0] pwr;
        logic [NCH*ACC_W-1:0]    snap;
    } item_t;

    item_t sbq[$];
    int    order_q[$];
    logic signed [ACC_W-1:0] m_acc [NCH];
    logic [15:0]             d_bus [NCH];
    logic [15:0]             d_sense [NCH];
    logic                    m_ovf;
    logic [CNT_W-1:0]        m_cnt;
    bit    wrong_first, ref_with_next;
    int    tests, fails, done_total;
    longint cyc, last_done, gap;
    logic  acc_seen, done_seen, prev_done;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic signed [PWR_W-1:0] exp_power(input logic [15:0] b, input logic [15:0] s);
        longint p;
        p = longint'($signed(s)) * longint'(b >> 2);
        p = p >>> 3;
        return PWR_W'(p);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < NCH; k++) m_acc[k] = '0;
        m_cnt = '0;
        m_ovf = 1'b0;
    endtask

    // Driver: answers each request and pushes the expected outcome.
    initial begin
        int ch;
        item_t it;
        logic signed [ACC_W-1:0] add, sum;
        r_valid = 0; r_chan = '0; r_bus = '0; r_sense = '0; r_refresh = 0;
        forever begin
            @(negedge clk);
            if (smp_req && rst_n) begin
                ch = int'(req_chan);
                if (wrong_first) begin
                    r_valid = 1; r_chan = CH_W'(ch ^ 1); r_bus = 16'hFFFF; r_sense = 16'h7FFF;
                    @(negedge clk);
                end
                r_valid = 1; r_chan = CH_W'(ch); r_bus = d_bus[ch]; r_sense = d_sense[ch];
                if (ref_with_next) begin
                    r_refresh = 1; ref_with_next = 0;
                    model_clear();
                end
                it.ch  = ch;
                it.pwr = exp_power(d_bus[ch], d_sense[ch]);
                add = ACC_W'(it.pwr);
                sum = m_acc[ch] + add;
                if (m_acc[ch][ACC_W-1] == add[ACC_W-1] && sum[ACC_W-1] != add[ACC_W-1]) m_ovf = 1'b1;
                m_acc[ch] = sum;
                for (int k = 0; k < NCH; k++) it.snap[k*ACC_W +: ACC_W] = m_acc[k];
                sbq.push_back(it);
                order_q.push_back(ch);
                @(negedge clk);
                r_valid = 0; r_refresh = 0;
            end
        end
    end

    always @(posedge clk) begin
        acc_seen  <= rst_n && smp_valid && smp_req && (smp_chan == req_chan);
        done_seen <= scan_done;
        cyc       <= cyc + 1;
    end

    // Monitor: pops expected items and compares as results appear.
    initial begin
        item_t it;
        prev_done = 0;
        forever begin
            @(negedge clk);
            if (acc_seen) begin
                if (sbq.size() == 0) chk(0, "R2 unexpected accept", 1, 0);
                else begin
                    it = sbq.pop_front();
                    chk($signed(pwr_flat[it.ch*PWR_W +: PWR_W]) == it.pwr, "R3 power",
                        longint'($signed(pwr_flat[it.ch*PWR_W +: PWR_W])), longint'(it.pwr));
                    for (int k = 0; k < NCH; k++)
                        chk(acc_flat[k*ACC_W +: ACC_W] == it.snap[k*ACC_W +: ACC_W], "R4 R2 accumulator",
                            longint'($signed(acc_flat[k*ACC_W +: ACC_W])),
                            longint'($signed(it.snap[k*ACC_W +: ACC_W])));
                    if (ovf_alert_en && !done_alert_en) chk(alert == m_ovf, "R9 alert", alert, m_ovf);
                end
            end
            if (scan_done) begin
                chk(!prev_done, "R6 single pulse", prev_done, 0);
                chk(alert == (done_alert_en | (ovf_alert_en & m_ovf)), "R10 done alert",
                    alert, done_alert_en | (ovf_alert_en & m_ovf));
                done_total++;
                gap = cyc - last_done;
                last_done = cyc;
            end
            if (done_seen) begin
                if (&m_cnt) m_ovf = 1'b1;
                m_cnt = m_cnt + CNT_W'(1);
                chk(acc_count == m_cnt, "R5 count", acc_count, m_cnt);
            end
            prev_done = scan_done;
        end
    end

    task automatic wait_done(input int k);
        int tgt;
        tgt = done_total + k;
        while (done_total < tgt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic main_clear();
        m_refresh = 1;
        model_clear();
        @(negedge clk);
        m_refresh = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ord_exp[3];
        tests = 0; fails = 0; done_total = 0; cyc = 0; last_done = 0; gap = 0;
        chan_mask = '0; rate_sel = 2'd3; ovf_alert_en = 0; done_alert_en = 0;
        m_refresh = 0; m_valid = 0; m_chan = '0; m_bus = '0; m_sense = '0;
        wrong_first = 0; ref_with_next = 0;
        model_clear();
        d_bus[0] = 16'h8000; d_sense[0] = 16'd1000;
        d_bus[1] = 16'hFFFF; d_sense[1] = 16'h8000;
        d_bus[2] = 16'h1234; d_sense[2] = 16'd77;
        d_bus[3] = 16'h0004; d_sense[3] = 16'hFFFF;

        repeat (4) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        chk(acc_flat == '0, "R12 acc", longint'(acc_flat[31:0]), 0);
        chk(pwr_flat == '0, "R12 power", longint'(pwr_flat[27:0]), 0);
        chk(acc_count == '0, "R12 count", acc_count, 0);
        chk(!smp_req && !scan_done && !alert, "R12 outputs", {smp_req, scan_done, alert}, 0);

        // R8: empty mask runs no scan
        repeat (300) @(negedge clk);
        chk(done_total == 0, "R8 no scan", done_total, 0);
        chk(acc_count == '0, "R8 count", acc_count, 0);
        chk(order_q.size() == 0, "R8 no request", order_q.size(), 0);

        // R1: scan order with a gap in the mask
        chan_mask = 4'b1011; done_alert_en = 1;
        wait_done(1);
        ord_exp = '{0, 1, 3};
        chk(order_q.size() == 3, "R1 scan length", order_q.size(), 3);
        for (int k = 0; k < 3; k++) chk(order_q[k] == ord_exp[k], "R1 scan order", order_q[k], ord_exp[k]);

        // R7: period length at two rates
        wait_done(1);
        chk(gap == 64, "R7 rate 1024", gap, 64);
        rate_sel = 2'd2;
        wait_done(2);
        chk(gap == 256, "R7 rate 256", gap, 256);
        rate_sel = 2'd3;
        wait_done(2);
        chk(gap == 64, "R7 rate back", gap, 64);

        // R2: stray sample while idle, then wrong-channel presentations
        m_valid = 1; m_chan = '0; m_bus = 16'hFFFF; m_sense = 16'h7FFF;
        @(negedge clk);
        m_valid = 0;
        @(negedge clk);
        for (int k = 0; k < NCH; k++)
            chk(acc_flat[k*ACC_W +: ACC_W] == m_acc[k], "R2 stray sample",
                longint'($signed(acc_flat[k*ACC_W +: ACC_W])), longint'(m_acc[k]));
        chk($signed(pwr_flat[0 +: PWR_W]) == exp_power(d_bus[0], d_sense[0]), "R2 power kept",
            longint'($signed(pwr_flat[0 +: PWR_W])), longint'(exp_power(d_bus[0], d_sense[0])));
        wrong_first = 1;
        wait_done(1);
        wrong_first = 0;

        // R11: standalone clear, then clear with a same-cycle sample
        main_clear();
        chk(acc_flat == '0, "R11 clear acc", longint'(acc_flat[31:0]), 0);
        chk(acc_count == '0, "R11 clear count", acc_count, 0);
        ref_with_next = 1;
        wait_done(1);
        chk(acc_count == CNT_W'(1), "R11 count after clear", acc_count, 1);

        // R9: accumulator overflow, stickiness, clear
        done_alert_en = 0; ovf_alert_en = 1; chan_mask = 4'b0001;
        d_bus[0] = 16'hFFFF; d_sense[0] = 16'h7FFF;
        main_clear();
        wait_done(32);
        chk(alert == 1'b0, "R9 no overflow yet", alert, 0);
        wait_done(1);
        chk(alert == 1'b1, "R9 overflow", alert, 1);
        wait_done(1);
        chk(alert == 1'b1, "R9 sticky", alert, 1);
        main_clear();
        chk(alert == 1'b0, "R11 flag cleared", alert, 0);

        // R9 and R5: count wrap
        d_sense[0] = 16'h0000;
        wait_done(63);
        chk(alert == 1'b0, "R9 before wrap", alert, 0);
        wait_done(1);
        chk(acc_count == '0, "R5 wrap", acc_count, 0);
        chk(alert == 1'b1, "R9 count wrap", alert, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule